// File: doc/BRIEF.md
# Per-Channel Serial Interrupt Enable and Status Logic

This block collects the interrupt sources of one serial channel into a single status byte. It keeps a seven-bit enable mask and drives one active-low interrupt request line. The sources are the transmitter's buffer-empty level and the receiver's full, parity and combined error levels. Three edge-detected handshake lines (clear-to-send, carrier detect and set-ready) add one transition flag each. The handshake lines arrive asynchronously. Each passes through a two-flop synchroniser before its level is used or its edges are detected.

The host reads the status byte combinationally through `stat_byte`. It pulses `stat_rd` in the cycle of the read, and that strobe clears the three transition flags. The host writes the enable mask with a set/clear protocol: the top bit of the written byte picks "set" or "clear", and only the mask bits written as 1 are affected. The block has no streaming data path. Every pin is a plain level or single-cycle strobe with no back-pressure.

Top module: `chan_irq_ctl`

## Requirements
- R1: On `en_wr` with `en_wdata[7]`=1, each enable whose bit in `en_wdata[6:0]` is 1 becomes 1, and the others keep their value. Writing 0xFF enables all seven sources.
- R2: On `en_wr` with `en_wdata[7]`=0, each enable whose bit in `en_wdata[6:0]` is 1 becomes 0, and the others keep their value. Writing 0x7F disables all seven sources.
- R3: During and after reset, `en_byte` reads 0x80, `irq_n` is 1 and the three transition flags are 0. Bit 7 of `en_byte` always reads 1, and bits 6..0 are the enables, laid out in the same positions as the status bits.
- R4: The status bit positions are: bit 0 = receive full (`rx_buf_full`), bit 1 = receive error (`rx_err_any`), bit 2 = parity status (`rx_par_stat`), bit 3 = set-ready transition, bit 4 = carrier transition, bit 5 = clear-to-send transition, bit 6 = transmit empty. Bits 2..0 follow their inputs in the same cycle.
- R5: Status bit 7 is 1 when any of bits 6..0 is 1, or when the synchronised clear-to-send line is high and `echo_on` is 0.
- R6: Status bit 6 equals `tx_buf_empty` while the synchronised clear-to-send line is low, and is 0 while it is high. A change on `hs_clear_line` takes effect on the status byte two clock edges after it is sampled.
- R7: A rising or falling edge on a handshake line sets its transition flag. The flag is visible one cycle after the synchronised level changes, that is three edges after the input is sampled. A cycle with `stat_rd`=1 clears all three flags at its closing edge.
- R8: When an edge sets a flag in the same cycle as a status read, the flag ends up set.
- R9: `irq_n` is a register. It is 0 in the cycle after one with (status[6:0] AND enables) nonzero, and 1 in the cycle after one where that AND is zero. A status of 0x80 caused only by the clear-to-send line never lowers it.
- R10: A handshake line held at a constant level since reset never sets its transition flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_clear_line | input | 1 | Asynchronous clear-to-send handshake line (high = not clear) |
| hs_carrier_line | input | 1 | Asynchronous carrier detect handshake line |
| hs_ready_line | input | 1 | Asynchronous set-ready handshake line |
| echo_on | input | 1 | Echo mode enabled |
| tx_buf_empty | input | 1 | Transmit data buffer empty (level from transmitter) |
| rx_par_stat | input | 1 | Parity status (level from receiver) |
| rx_err_any | input | 1 | Framing, overrun or break seen (level from receiver) |
| rx_buf_full | input | 1 | Receive data buffer full (level from receiver) |
| stat_rd | input | 1 | Status byte is being read this cycle |
| en_wr | input | 1 | Enable mask write strobe |
| en_wdata | input | 8 | Enable write byte: bit 7 selects set/clear, bits 6..0 select sources |
| stat_byte | output | 8 | Assembled status byte |
| en_byte | output | 8 | Enable mask readback (bit 7 reads 1) |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
The bench drives a handshake edge so that it lands in a cycle where a read is held. A design that lets the read win would lose that flag and show a cleared bit 4. It holds the clear-to-send and carrier lines high from reset onward. A synchroniser that detects its own reset transition would raise a spurious flag, and a summary bit wired into the interrupt would pull `irq_n` low with every enable set. It writes enable bytes with a mix of zero and one bits in both directions. A plain load instead of set/clear shows up at once on `en_byte`. It also samples `irq_n` just before and just after the edge that follows a cause clearing, which exposes a combinational or late interrupt.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int N_SRC      = 7;
  localparam int N_LINES    = 3;
  // handshake line indices inside the synchroniser vector
  localparam int LN_CLEAR   = 0;
  localparam int LN_CARRIER = 1;
  localparam int LN_READY   = 2;
  // status byte bit positions
  localparam int B_RXFULL   = 0;
  localparam int B_RXERR    = 1;
  localparam int B_PAR      = 2;
  localparam int B_READYT   = 3;
  localparam int B_CARRT    = 4;
  localparam int B_CLEART   = 5;
  localparam int B_TXE      = 6;
  localparam int B_ANY      = 7;
endpackage

// File: rtl/hs_line_sync.sv
module hs_line_sync #(
  parameter int N_LINES     = 3,
  parameter int SYNC_STAGES = 2   // must be at least 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_in,
  output logic               first_lvl,
  output logic [N_LINES-1:0] line_edge
);
  localparam int PRIME = SYNC_STAGES + 1;
  localparam int CW    = $clog2(PRIME + 1);

  logic [CW-1:0]      prime_cnt;
  logic               primed;
  logic [N_LINES-1:0] line_lvl;

  // edges are suppressed until the pipeline holds only sampled values
  assign primed = (prime_cnt == CW'(PRIME));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prime_cnt <= '0;
    else if (!primed) prime_cnt <= prime_cnt + 1'b1;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] stg;
    logic                   prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg  <= '0;
        prev <= 1'b0;
      end else begin
        stg  <= {stg[SYNC_STAGES-2:0], line_in[g]};
        prev <= stg[SYNC_STAGES-1];
      end
    end

    assign line_lvl[g]  = stg[SYNC_STAGES-1];
    assign line_edge[g] = primed & (stg[SYNC_STAGES-1] ^ prev);

    // R7: a reported edge always matches a level change seen one cycle apart
    a_r7_edge_is_change: assert property (@(posedge clk) disable iff (!rst_n)
      line_edge[g] |-> (line_lvl[g] != $past(line_lvl[g])));
  end

  assign first_lvl = line_lvl[0];
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int N_SRC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [N_SRC:0]   wdata,
  output logic [N_SRC-1:0] en_q
);
  logic             set_mode;
  logic [N_SRC-1:0] sel;

  assign set_mode = wdata[N_SRC];
  assign sel      = wdata[N_SRC-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   en_q <= '0;
    else if (wr)  en_q <= set_mode ? (en_q | sel) : (en_q & ~sel);
  end

  // R1: selected bits become 1 in set mode
  a_r1_set_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && set_mode) |=> ((en_q & $past(sel)) == $past(sel)));
  // R2: selected bits become 0 in clear mode
  a_r2_clear_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !set_mode) |=> ((en_q & $past(sel)) == '0));
  // R1: unselected bits never move
  a_r1_keep_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((en_q ^ $past(en_q)) & ~($past(sel) & {N_SRC{$past(wr)}})) == '0));
endmodule

// File: rtl/irq_stat_build.sv
module irq_stat_build
  import chan_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd,
  input  logic [N_LINES-1:0] line_edge,
  input  logic               clear_lvl,
  input  logic               echo_on,
  input  logic               tx_empty,
  input  logic               rx_par,
  input  logic               rx_err,
  input  logic               rx_full,
  output logic [7:0]         stat
);
  logic [N_LINES-1:0] flag;
  logic [N_SRC-1:0]   low;

  // an edge in a read cycle survives the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= (flag & ~{N_LINES{rd}}) | line_edge;
  end

  always_comb begin
    low            = '0;
    low[B_RXFULL]  = rx_full;
    low[B_RXERR]   = rx_err;
    low[B_PAR]     = rx_par;
    low[B_READYT]  = flag[LN_READY];
    low[B_CARRT]   = flag[LN_CARRIER];
    low[B_CLEART]  = flag[LN_CLEAR];
    low[B_TXE]     = tx_empty & ~clear_lvl;
  end

  assign stat = {(|low) | (clear_lvl & ~echo_on), low};

  // R8: an edge always leaves its flag set, read or not
  a_r8_edge_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
    (line_edge != '0) |=> ((flag & $past(line_edge)) == $past(line_edge)));
  // R7: a read clears every flag that had no new edge
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> ((flag & ~$past(line_edge)) == '0));
  // R10: with no edge and no read, flags hold
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && line_edge == '0) |=> $stable(flag));
  // R6: transmit empty is masked while the clear line is high
  a_r6_txe_masked: assert property (@(posedge clk) disable iff (!rst_n)
    clear_lvl |-> !stat[B_TXE]);
endmodule

// File: rtl/chan_irq_ctl.sv
module chan_irq_ctl
  import chan_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_clear_line,
  input  logic       hs_carrier_line,
  input  logic       hs_ready_line,
  input  logic       echo_on,
  input  logic       tx_buf_empty,
  input  logic       rx_par_stat,
  input  logic       rx_err_any,
  input  logic       rx_buf_full,
  input  logic       stat_rd,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  output logic [7:0] stat_byte,
  output logic [7:0] en_byte,
  output logic       irq_n
);
  logic [N_LINES-1:0] line_in;
  logic [N_LINES-1:0] line_edge;
  logic               clear_lvl;
  logic [N_SRC-1:0]   en_q;
  logic               cause;

  always_comb begin
    line_in             = '0;
    line_in[LN_CLEAR]   = hs_clear_line;
    line_in[LN_CARRIER] = hs_carrier_line;
    line_in[LN_READY]   = hs_ready_line;
  end

  hs_line_sync #(.N_LINES(N_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .first_lvl(clear_lvl), .line_edge(line_edge)
  );

  irq_en_reg #(.N_SRC(N_SRC)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata), .en_q(en_q)
  );

  irq_stat_build u_stat (
    .clk(clk), .rst_n(rst_n), .rd(stat_rd), .line_edge(line_edge),
    .clear_lvl(clear_lvl), .echo_on(echo_on), .tx_empty(tx_buf_empty),
    .rx_par(rx_par_stat), .rx_err(rx_err_any), .rx_full(rx_buf_full),
    .stat(stat_byte)
  );

  assign en_byte = {1'b1, en_q};
  assign cause   = |(stat_byte[N_SRC-1:0] & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~cause;
  end

  // R9: request follows an enabled cause one cycle later
  a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> !irq_n);
  // R9: request drops one cycle after the cause goes away
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !cause |=> irq_n);
  // R3: enable readback top bit is constant one
  a_r3_en_top: assert property (@(posedge clk) disable iff (!rst_n)
    en_byte[7]);
endmodule

// File: tb/tb_chan_irq_ctl.sv
module tb_chan_irq_ctl;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic clr = 1'b1, car = 1'b1, rdy = 1'b0, echo = 1'b0;
  logic txe = 1'b0, par = 1'b0, err = 1'b0, full = 1'b0;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] stat_byte, en_byte;
  logic irq_n;

  chan_irq_ctl #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .hs_clear_line(clr), .hs_carrier_line(car),
    .hs_ready_line(rdy), .echo_on(echo), .tx_buf_empty(txe),
    .rx_par_stat(par), .rx_err_any(err), .rx_buf_full(full),
    .stat_rd(rd), .en_wr(wr), .en_wdata(wdata),
    .stat_byte(stat_byte), .en_byte(en_byte), .irq_n(irq_n)
  );

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [2:0] hq[$];       // sampled lines: bit0 clear, bit1 carrier, bit2 ready
  logic [2:0] m_flag = '0; // bit0 clear, bit1 carrier, bit2 ready
  logic [6:0] m_en   = '0;
  logic       m_irq_n = 1'b1;

  function automatic logic [2:0] m_lvl();
    if (hq.size() >= SYNC) return hq[hq.size()-SYNC];
    return 3'b000;
  endfunction

  function automatic logic [2:0] m_edge();
    if (hq.size() >= SYNC + 1) return hq[hq.size()-SYNC] ^ hq[hq.size()-SYNC-1];
    return 3'b000;
  endfunction

  function automatic logic [7:0] m_stat();
    logic [2:0] l;
    logic [6:0] lo;
    l  = m_lvl();
    lo = {txe & ~l[0], m_flag[0], m_flag[1], m_flag[2], par, err, full};
    return {(|lo) | (l[0] & ~echo), lo};
  endfunction

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] s;
    s = m_stat();
    chk("R1/R2/R3 en_byte", en_byte, {1'b1, m_en});
    chk("R5 summary bit", {7'd0, stat_byte[7]}, {7'd0, s[7]});
    chk("R6 tx empty bit", {7'd0, stat_byte[6]}, {7'd0, s[6]});
    chk("R7 transition flags", {5'd0, stat_byte[5:3]}, {5'd0, s[5:3]});
    chk("R4 receive fields", {5'd0, stat_byte[2:0]}, {5'd0, s[2:0]});
    chk("R9 irq_n", {7'd0, irq_n}, {7'd0, m_irq_n});
  endtask

  task automatic step();
    logic [7:0] s;
    logic [2:0] e;
    @(posedge clk);
    if (!rst_n) begin
      hq.delete();
      m_flag  = '0;
      m_en    = '0;
      m_irq_n = 1'b1;
    end else begin
      s = m_stat();
      e = m_edge();
      m_irq_n = ~|(s[6:0] & m_en);
      m_flag  = (m_flag & {3{~rd}}) | e;
      if (wr) m_en = wdata[7] ? (m_en | wdata[6:0]) : (m_en & ~wdata[6:0]);
      hq.push_back({rdy, car, clr});
      if (hq.size() > SYNC + 1) void'(hq.pop_front());
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_en(input logic [7:0] v);
    wdata = v; wr = 1'b1;
    step();
    wr = 1'b0; wdata = 8'h00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    @(negedge clk);
    steps(4);
    chk("R3 en_byte in reset", en_byte, 8'h80);
    chk("R3 irq_n in reset", {7'd0, irq_n}, 8'h01);
    chk("R3 flags in reset", {5'd0, stat_byte[5:3]}, 8'h00);

    rst_n = 1'b1;
    steps(6);
    chk("R10/R5 lines static since reset", stat_byte, 8'h80);

    write_en(8'hFF);
    steps(2);
    chk("R1 enable all", en_byte, 8'hFF);
    chk("R9 summary-only status no request", {7'd0, irq_n}, 8'h01);

    echo = 1'b1;
    step();
    chk("R5 echo hides clear line", stat_byte, 8'h00);

    write_en(8'h05);
    chk("R2 clear selected", en_byte, 8'hFA);
    write_en(8'h81);
    chk("R1 set selected", en_byte, 8'hFB);
    write_en(8'h7F);
    chk("R2 disable all", en_byte, 8'h80);

    txe = 1'b1;
    step();
    chk("R6 tx empty masked by clear line", {7'd0, stat_byte[6]}, 8'h00);
    clr = 1'b0;
    steps(2);
    chk("R6 tx empty after sync", stat_byte, 8'hC0);
    step();
    chk("R7 clear-line transition flag", stat_byte, 8'hE0);

    write_en(8'hC0);
    chk("R9 no request yet", {7'd0, irq_n}, 8'h01);
    step();
    chk("R9 request one cycle on", {7'd0, irq_n}, 8'h00);

    rd = 1'b1;
    step();
    rd = 1'b0;
    chk("R7 read clears flag", stat_byte, 8'hC0);

    txe = 1'b0;
    #1;
    chk("R9 request is registered", {7'd0, irq_n}, 8'h00);
    @(negedge clk);
    step();
    chk("R9 request drops after cause", {7'd0, irq_n}, 8'h01);

    car = 1'b0;
    rd  = 1'b1;
    steps(3);
    rd  = 1'b0;
    chk("R8 edge during read sets flag", {7'd0, stat_byte[4]}, 8'h01);
    rd = 1'b1; step(); rd = 1'b0;

    rdy = 1'b1;
    steps(3);
    chk("R7 ready-line transition flag", stat_byte, 8'h88);
    rd = 1'b1; step(); rd = 1'b0;

    full = 1'b1; err = 1'b1;
    step();
    chk("R4 receive full and error", stat_byte, 8'h83);
    write_en(8'h81);
    step();
    chk("R9 request on receive full", {7'd0, irq_n}, 8'h00);
    write_en(8'h01);
    step();
    chk("R2/R9 request gone after disable", {7'd0, irq_n}, 8'h01);
    par = 1'b1;
    step();
    chk("R4 parity bit", stat_byte, 8'h87);

    lf = 32'h1D2C_3B4A;
    for (int i = 0; i < 600; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      if (lf[3:0] == 4'h0) clr = ~clr;
      if (lf[7:4] == 4'h1) car = ~car;
      if (lf[11:8] == 4'h2) rdy = ~rdy;
      echo = lf[12] & lf[13];
      txe  = lf[14];
      par  = lf[15] & lf[16];
      err  = lf[17] & lf[18];
      full = lf[19];
      rd   = (lf[22:20] == 3'd0);
      wr   = (lf[25:23] == 3'd0);
      wdata = lf[31:24];
      step();
    end
    rd = 1'b0; wr = 1'b0;
    step();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule